// File: doc/BRIEF.md
# Real-Mode Address Generator with Bit-20 Gate

This block turns a 16-bit segment value and a 16-bit offset into a physical byte address the way a legacy real-mode processor does: the segment is moved up by four bit positions and the offset is added. The sum is kept to 21 bits, so a carry past the 1 MiB boundary becomes a real address bit. That bit is passed through a gate. With the gate closed, the address wraps back to the bottom of memory. With the gate open, the top 65520 bytes just above 1 MiB can be reached.

A requester raises `req` together with a segment and an offset. One clock later the registered address appears with `valid`, and `hma` marks a result that lies above 1 MiB. The gate level is registered once per clock. A request therefore uses the level that `gate_en` had at the previous edge, and right after reset it uses a closed gate.

The control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_VALID` means a result is on the outputs. There are four transitions: IDLE to VALID on `req`, VALID to VALID on `req` (back-to-back requests), VALID to IDLE when `req` is low, and IDLE to IDLE when `req` is low. Reset forces `ST_IDLE`.

Top module: `rmag_top`

## Requirements
- R1: For every request the address is (segment × 16) + offset, computed to 21 bits without truncation before the gate.
- R2: The address never exceeds 10FFEFh. Segment FFFFh with offset FFFFh and the gate open gives exactly 10FFEFh.
- R3: With the gate closed, output bit 20 is 0, so the result is the sum modulo 2^20. FFFF:0010h gives 00000h and FFFF:FFFFh gives 0FFEFh.
- R4: With the gate open, bit 20 of the sum reaches the output. FFFF:0010h gives 100000h, and FFFF:000Fh still gives FFFFFh.
- R5: Distinct pairs that name one location give one address: 9000:8000h and 9300:5000h both give 98000h.
- R6: The gate level used by a request is the `gate_en` value sampled at the previous rising edge. The sampled level is 0 after reset, so a request in the first cycle after reset wraps even if `gate_en` is 1.
- R7: `hma` is 1 exactly when output bit 20 of `phys` is 1.
- R8: `valid` is 1 in the cycle after each cycle with `req` high and 0 otherwise. Back-to-back requests give back-to-back results, each with its own address.
- R9: When `req` is low, `phys` and `hma` keep their previous values.
- R10: Reset is synchronous and active-high. It clears `phys` to 0, `valid` to 0 and `hma` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; samples seg and off |
| seg | input | 16 | Segment value |
| off | input | 16 | Offset value |
| gate_en | input | 1 | Bit-20 gate enable, registered each clock |
| phys | output | 21 | Registered physical address |
| valid | output | 1 | Result strobe, one cycle after req |
| hma | output | 1 | Result lies above 1 MiB |

## Verification
Two things can happen in the same cycle: a change of the gate level and a request whose sum carries into bit 20. The bench provokes this by raising `gate_en` in the first cycle after reset together with a request for FFFF:0010h. It expects 00000h, because the request must see the previously sampled closed gate. It then lowers the gate in the same cycle as a second carrying request and expects 100000h, because that request still sees the open level sampled one edge earlier.

// File: rtl/rmag_pkg.sv
package rmag_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } rmag_state_e;
endpackage

// File: rtl/rmag_adder.sv
// Shift the segment up and add the offset, keeping the carry bit.
module rmag_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int SUM_W = SEG_W + SHIFT + 1
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [SUM_W-1:0] sum
);
    logic [SUM_W-1:0] seg_ext;
    logic [SUM_W-1:0] off_ext;

    always_comb begin
        seg_ext = {1'b0, seg, {SHIFT{1'b0}}};
        off_ext = SUM_W'(off);
        sum     = seg_ext + off_ext;
    end
endmodule

// File: rtl/rmag_gate.sv
// Registers the gate level and masks the top bit of the sum with it.
module rmag_gate #(
    parameter int SUM_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_en,
    input  logic [SUM_W-1:0] sum_in,
    output logic [SUM_W-1:0] masked,
    output logic             top_bit
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_en;
    end

    always_comb begin
        top_bit = sum_in[SUM_W-1] & gate_q;
        masked  = {top_bit, sum_in[SUM_W-2:0]};
    end
endmodule

// File: rtl/rmag_top.sv
module rmag_top #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic              gate_en,
    output logic [ADDR_W-1:0] phys,
    output logic              valid,
    output logic              hma
);
    import rmag_pkg::*;

    rmag_state_e      state_q, state_d;
    logic [ADDR_W-1:0] sum_w, masked_w;
    logic              top_w;
    logic [ADDR_W-1:0] phys_q;
    logic              hma_q;

    rmag_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg (seg),
        .off (off),
        .sum (sum_w)
    );

    rmag_gate #(.SUM_W(ADDR_W)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .gate_en (gate_en),
        .sum_in  (sum_w),
        .masked  (masked_w),
        .top_bit (top_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = req ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // result registers, loaded only on a request
    always_ff @(posedge clk) begin
        if (rst) begin
            phys_q <= '0;
            hma_q  <= 1'b0;
        end else if (req) begin
            phys_q <= masked_w;
            hma_q  <= top_w;
        end
    end

    // outputs
    always_comb begin
        valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  valid = 1'b0;
            ST_VALID: valid = 1'b1;
            default:  valid = 1'b0;
        endcase
        phys = phys_q;
        hma  = hma_q;
    end
endmodule

// File: rtl/rmag_chk.sv
module rmag_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              gate_en,
    input logic [ADDR_W-1:0] phys,
    input logic              valid,
    input logic              hma
);
    localparam logic [ADDR_W-1:0] MAX_ADDR = ADDR_W'(21'h10FFEF);

    // R8: a request yields a result strobe next cycle
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req |=> valid);
    // R8: no strobe without a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req |=> !valid);
    // R7: flag tracks output bit 20
    a_r7_hma_bit: assert property (@(posedge clk) disable iff (rst)
        hma == phys[ADDR_W-1]);
    // R3/R6: closed gate at the previous edge forces a wrap
    a_r3_wrap_closed: assert property (@(posedge clk) disable iff (rst)
        (req && !$past(gate_en)) |=> !phys[ADDR_W-1]);
    // R9: outputs hold without a request
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(phys) && $stable(hma)));
    // R2: upper bound
    a_r2_range: assert property (@(posedge clk) disable iff (rst)
        phys <= MAX_ADDR);
    // R10: synchronous reset clears everything
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (phys == '0 && !valid && !hma));
endmodule

bind rmag_top rmag_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .gate_en (gate_en),
    .phys    (phys),
    .valid   (valid),
    .hma     (hma)
);

// File: tb/sim_rmag_top.sv
`timescale 1ns/1ps
module sim_rmag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [15:0] seg = '0;
    logic [15:0] off = '0;
    logic        gate_en = 1'b0;
    logic [20:0] phys;
    logic        valid;
    logic        hma;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rmag_top u0 (.clk(clk), .rst(rst), .req(req), .seg(seg), .off(off),
                 .gate_en(gate_en), .phys(phys), .valid(valid), .hma(hma));

    // {seg, off, gate, expected}
    localparam int NV = 11;
    localparam logic [53:0] VEC [NV] = '{
        {16'h9000, 16'h8000, 1'b0, 21'h098000},  // R5
        {16'h9300, 16'h5000, 1'b0, 21'h098000},  // R5
        {16'hFFFF, 16'h0010, 1'b0, 21'h000000},  // R3
        {16'hFFFF, 16'h0010, 1'b1, 21'h100000},  // R4
        {16'hFFFF, 16'hFFFF, 1'b1, 21'h10FFEF},  // R2
        {16'hFFFF, 16'hFFFF, 1'b0, 21'h00FFEF},  // R3
        {16'hFFFF, 16'h000F, 1'b1, 21'h0FFFFF},  // R4
        {16'h0000, 16'h0000, 1'b1, 21'h000000},  // R1
        {16'h1234, 16'h5678, 1'b1, 21'h0179B8},  // R1
        {16'hF800, 16'h8000, 1'b0, 21'h000000},  // R3
        {16'hF800, 16'h8000, 1'b1, 21'h100000}   // R4
    };

    task automatic chk(input string tag, input logic [20:0] got, input logic [20:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [20:0] model(input logic [15:0] s, input logic [15:0] o, input logic g);
        logic [20:0] r;
        r = {1'b0, s, 4'h0} + {5'h0, o};
        r[20] = r[20] & g;
        return r;
    endfunction

    // gate set one cycle ahead, then one request, checked next cycle
    task automatic one_req(input logic [15:0] s, input logic [15:0] o, input logic g,
                           input logic [20:0] exp, input string tag);
        gate_en = g;
        @(negedge clk);
        req = 1'b1; seg = s; off = o;
        @(negedge clk);
        req = 1'b0;
        chk({tag, " addr"}, phys, exp);
        chk({tag, " model"}, phys, model(s, o, g));
        chk("R7 hma", {20'h0, hma}, {20'h0, exp[20]});
        chk("R8 valid", {20'h0, valid}, 21'h1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R10 reset phys", phys, 21'h0);
        chk("R10 reset valid", {20'h0, valid}, 21'h0);
        chk("R10 reset hma", {20'h0, hma}, 21'h0);

        // R6: gate raised with a request in the first cycle after reset
        rst = 1'b0; gate_en = 1'b1; req = 1'b1; seg = 16'hFFFF; off = 16'h0010;
        @(negedge clk);
        chk("R6 first cycle wraps", phys, 21'h0);
        chk("R8 valid first", {20'h0, valid}, 21'h1);
        // gate now open; lower it together with the next request
        gate_en = 1'b0;
        @(negedge clk);
        chk("R6 previous-edge level", phys, 21'h100000);
        chk("R7 hma high", {20'h0, hma}, 21'h1);
        chk("R8 back-to-back valid", {20'h0, valid}, 21'h1);
        req = 1'b0;

        // R9: no request, outputs hold, valid drops
        @(negedge clk);
        chk("R8 valid drops", {20'h0, valid}, 21'h0);
        seg = 16'h0001; off = 16'h0001; gate_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 hold phys", phys, 21'h100000);
        chk("R9 hold hma", {20'h0, hma}, 21'h1);

        for (int i = 0; i < NV; i++) begin
            one_req(VEC[i][53:38], VEC[i][37:22], VEC[i][21], VEC[i][20:0], "R1/R2/R3/R4/R5 vec");
        end

        // R10: reset after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset again phys", phys, 21'h0);
        chk("R10 reset again valid", {20'h0, valid}, 21'h0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule